// File: doc/BRIEF.md
# Serial Flash Status Register Engine

This block is the status-register part of a serial flash device, seen from the SPI side. It holds two 8-bit status registers and decodes the SPI commands that read them, arm a write and write them. The SPI pins are oversampled by a faster system clock. The command and data bits are taken on rising SCLK while chip select is low, MSB first. Read data changes on falling SCLK. Both idle-low (mode 0) and idle-high (mode 3) clocking work.

Each register has a non-volatile image that survives reset and a volatile working copy, which is the copy the host reads. A write can be armed in two ways. The first arms a non-volatile write: it updates both copies and then holds BUSY for a fixed number of system clocks. The second arms a one-shot write to the volatile copy only, and WEL stays 0. Read-only bits are masked on every write. The lock and protect-1 bits can only be set, never cleared. Reset models power-on: the working copy is reloaded from the non-volatile image and all arming state is cleared.

SPI timing rule: each SCLK half period and each chip-select setup or hold must last at least SYNC_STAGES+4 system clocks.

Top module: `spi_sr_engine`

## Requirements
- R1: Opcode 05h returns status register 1. Bit 7 is PROT0, bit 6 is SECT, bit 5 is TOPBOT, bits 4:2 are BPROT, bit 1 is WEL and bit 0 is BUSY. The MSB goes out first. The first bit appears after the first falling SCLK that follows the opcode's eighth rising SCLK, and each later bit changes on a falling edge.
- R2: Opcode 35h returns status register 2. Bit 0 is PROT1, bit 1 is QUAD, bit 2 is reserved (always 0), bits 5:3 are LOCK[3:1], bit 6 is COMPL and bit 7 is SUSP (always 0).
- R3: While chip select stays low, a status read keeps repeating the selected register every 8 clocks, each time with its current value.
- R4: Commands work the same in SPI mode 0 and in SPI mode 3.
- R5: After 06h, WEL reads 1. The command 01h, d1 [, d2], closed at a byte boundary, writes register 1 from d1. It writes register 2 only when d2 is present; with d1 alone, register 2 is unchanged.
- R6: A 01h command with neither write arming is ignored and leaves both registers unchanged.
- R7: Writes never change register 1 bits 1:0, register 2 bit 2 or register 2 bit 7.
- R8: A committed non-volatile write holds BUSY=1 and WEL=1 for BUSY_CYCLES system clocks, then clears both. Reads are served during this time. 06h, 50h and 01h received during this time are ignored.
- R9: After 50h, the next 01h changes only the volatile copy and leaves WEL=0 and BUSY=0. The arming is used up by that one write, and a reset restores the non-volatile values.
- R10: Once register 2 bit 0, 3, 4 or 5 reads 1, no write of either kind clears it.
- R11: If chip select rises in the middle of a byte, the whole command is dropped and no state changes.
- R12: spi_miso_oe is 0 except from the first read-data falling edge until chip select rises. spi_miso is 0 whenever spi_miso_oe is 0.
- R13: Reset loads the working registers from the non-volatile image and clears BUSY, WEL and the volatile arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low reset, acting as power-on |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (low means high impedance) |

## Verification
The bench builds the block with BUSY_CYCLES=600, SYNC_STAGES=2, NV1_INIT=8'h08 and NV2_INIT=8'h02. With a 600-clock BUSY window, a full status poll and an ignored arming command both fit inside one write cycle, and the window still ends quickly. The non-zero start values make the reload at reset visible, so a volatile write can be seen to vanish. The lock bits can then be watched staying set across both write kinds.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam logic [7:0] OP_READ1    = 8'h05;
  localparam logic [7:0] OP_READ2    = 8'h35;
  localparam logic [7:0] OP_ARM_NV   = 8'h06;
  localparam logic [7:0] OP_ARM_VOL  = 8'h50;
  localparam logic [7:0] OP_WRITE_SR = 8'h01;

  // writable fields per register, and the set-only fields of register 2
  localparam logic [7:0] SR1_WR_MASK  = 8'hFC;
  localparam logic [7:0] SR2_WR_MASK  = 8'h7B;
  localparam logic [7:0] SR2_OTP_MASK = 8'h39;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ1, CMD_READ2, CMD_ARM_NV, CMD_ARM_VOL, CMD_WRITE_SR, CMD_OTHER
  } cmd_e;

  function automatic cmd_e decode_op(input logic [7:0] op);
    case (op)
      OP_READ1:    return CMD_READ1;
      OP_READ2:    return CMD_READ2;
      OP_ARM_NV:   return CMD_ARM_NV;
      OP_ARM_VOL:  return CMD_ARM_VOL;
      OP_WRITE_SR: return CMD_WRITE_SR;
      default:     return CMD_OTHER;
    endcase
  endfunction

  // new value: writable bits from data, others kept, set-only bits never drop
  function automatic logic [7:0] merge_sr(input logic [7:0] old, input logic [7:0] dat,
                                          input logic [7:0] wmask, input logic [7:0] otp);
    return (old & ~wmask) | (dat & wmask) | (old & otp);
  endfunction
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_end,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_q, csn_q, dat_q;
  logic [STAGES:0]   sck_in, csn_in, dat_in;
  logic              sck_d, act_d;

  assign sck_in = {sck_q, sclk};
  assign csn_in = {csn_q, cs_n};
  assign dat_in = {dat_q, mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      csn_q <= '1;
      dat_q <= '0;
      sck_d <= 1'b0;
      act_d <= 1'b0;
    end else begin
      sck_q <= sck_in[STAGES-1:0];
      csn_q <= csn_in[STAGES-1:0];
      dat_q <= dat_in[STAGES-1:0];
      sck_d <= sck_q[STAGES-1];
      act_d <= cs_act;
    end
  end

  assign cs_act    = ~csn_q[STAGES-1];
  assign cs_end    = act_d & ~cs_act;
  assign sclk_rise = sck_q[STAGES-1] & ~sck_d;
  assign sclk_fall = ~sck_q[STAGES-1] & sck_d;
  assign mosi_s    = dat_q[STAGES-1];
endmodule

// File: rtl/spi_sr_shifter.sv
module spi_sr_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       bit_stb,
  input  logic       bit_val,
  output logic       byte_vld,
  output logic [7:0] byte_dat,
  output logic [1:0] byte_idx,
  output logic       mid_byte
);
  logic [2:0] bit_cnt;
  logic [6:0] acc;
  logic [1:0] n_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      acc      <= '0;
      n_bytes  <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
      byte_idx <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0;
        n_bytes <= '0;
      end else if (bit_stb) begin
        acc     <= {acc[5:0], bit_val};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_dat <= {acc, bit_val};
          byte_idx <= n_bytes;
          if (n_bytes != 2'd3) n_bytes <= n_bytes + 2'd1;
        end
      end
    end
  end

  assign mid_byte = (bit_cnt != 3'd0);
endmodule

// File: rtl/spi_sr_regs.sv
module spi_sr_regs
  import spi_sr_pkg::*;
#(
  parameter int         BUSY_CYCLES = 1000,
  parameter logic [7:0] NV1_INIT    = 8'h00,
  parameter logic [7:0] NV2_INIT    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_nv_go,
  input  logic       arm_vol_go,
  input  logic       wr_go,
  input  logic       wr_two,
  input  logic [7:0] wr_d1,
  input  logic [7:0] wr_d2,
  output logic [7:0] sr1,
  output logic [7:0] sr2,
  output logic       busy,
  output logic       wel,
  output logic       vol_en
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  // non-volatile image: kept across reset, loaded only at power-up
  logic [7:0] nv1_q = NV1_INIT & SR1_WR_MASK;
  logic [7:0] nv2_q = NV2_INIT & SR2_WR_MASK;
  logic [7:0] vol1_q, vol2_q;
  logic [CW-1:0] busy_cnt;
  logic nv_commit, any_commit;

  assign nv_commit  = wr_go & ~busy & wel;
  assign any_commit = wr_go & ~busy & (wel | vol_en);

  always_ff @(posedge clk) begin
    if (rst_n && nv_commit) begin
      nv1_q <= merge_sr(nv1_q, wr_d1, SR1_WR_MASK, 8'h00);
      if (wr_two) nv2_q <= merge_sr(nv2_q, wr_d2, SR2_WR_MASK, SR2_OTP_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol1_q   <= nv1_q;
      vol2_q   <= nv2_q;
      busy     <= 1'b0;
      wel      <= 1'b0;
      vol_en   <= 1'b0;
      busy_cnt <= '0;
    end else if (busy) begin
      if (busy_cnt == '0) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else begin
        busy_cnt <= busy_cnt - 1'b1;
      end
    end else begin
      if (arm_nv_go)  wel    <= 1'b1;
      if (arm_vol_go) vol_en <= 1'b1;
      if (wr_go)      vol_en <= 1'b0;
      if (any_commit) begin
        vol1_q <= merge_sr(vol1_q, wr_d1, SR1_WR_MASK, 8'h00);
        if (wr_two) vol2_q <= merge_sr(vol2_q, wr_d2, SR2_WR_MASK, SR2_OTP_MASK);
      end
      if (nv_commit) begin
        busy     <= 1'b1;
        busy_cnt <= CW'(BUSY_CYCLES - 1);
      end
    end
  end

  assign sr1 = {vol1_q[7:2], wel, busy};
  assign sr2 = vol2_q;
endmodule

// File: rtl/spi_sr_engine.sv
module spi_sr_engine
  import spi_sr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         BUSY_CYCLES = 1000,
  parameter logic [7:0] NV1_INIT    = 8'h00,
  parameter logic [7:0] NV2_INIT    = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic sclk_rise, sclk_fall, cs_act, cs_end, mosi_s;
  logic byte_vld, mid_byte;
  logic [7:0] byte_dat;
  logic [1:0] byte_idx;
  logic [7:0] sr1_now, sr2_now;
  logic busy, wel, vol_en;

  cmd_e cmd_q;
  logic have1, have2;
  logic [7:0] d1_q, d2_q;
  logic closed_ok, arm_nv_go, arm_vol_go, wr_go;

  logic rd_act;
  logic [7:0] rd_src, out_sh;
  logic [2:0] rd_cnt;
  logic miso_q, oe_q;

  spi_sr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .cs_end(cs_end),
    .mosi_s(mosi_s)
  );

  spi_sr_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .bit_stb(sclk_rise), .bit_val(mosi_s),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_idx(byte_idx), .mid_byte(mid_byte)
  );

  spi_sr_regs #(.BUSY_CYCLES(BUSY_CYCLES), .NV1_INIT(NV1_INIT), .NV2_INIT(NV2_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .arm_nv_go(arm_nv_go), .arm_vol_go(arm_vol_go),
    .wr_go(wr_go), .wr_two(have2), .wr_d1(d1_q), .wr_d2(d2_q),
    .sr1(sr1_now), .sr2(sr2_now), .busy(busy), .wel(wel), .vol_en(vol_en)
  );

  // command and data byte capture for the current chip-select frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_NONE;
      have1 <= 1'b0;
      have2 <= 1'b0;
      d1_q  <= '0;
      d2_q  <= '0;
    end else if (!cs_act) begin
      cmd_q <= CMD_NONE;
      have1 <= 1'b0;
      have2 <= 1'b0;
    end else if (byte_vld) begin
      case (byte_idx)
        2'd0: cmd_q <= decode_op(byte_dat);
        2'd1: begin d1_q <= byte_dat; have1 <= 1'b1; end
        2'd2: begin d2_q <= byte_dat; have2 <= 1'b1; end
        default: ;
      endcase
    end
  end

  // a frame acts only when chip select rises on a byte boundary
  assign closed_ok  = cs_end & ~mid_byte;
  assign arm_nv_go  = closed_ok & (cmd_q == CMD_ARM_NV);
  assign arm_vol_go = closed_ok & (cmd_q == CMD_ARM_VOL);
  assign wr_go      = closed_ok & (cmd_q == CMD_WRITE_SR) & have1;

  // read-out: reload the live register value at every byte start
  assign rd_act = (cmd_q == CMD_READ1) | (cmd_q == CMD_READ2);
  assign rd_src = (cmd_q == CMD_READ2) ? sr2_now : sr1_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sh <= '0;
      rd_cnt <= '0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (!cs_act) begin
      rd_cnt <= '0;
      oe_q   <= 1'b0;
      miso_q <= 1'b0;
    end else if (sclk_fall && rd_act) begin
      oe_q   <= 1'b1;
      rd_cnt <= rd_cnt + 3'd1;
      if (rd_cnt == 3'd0) begin
        miso_q <= rd_src[7];
        out_sh <= {rd_src[6:0], 1'b0};
      end else begin
        miso_q <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
      end
    end
  end

  assign spi_miso    = oe_q & miso_q;
  assign spi_miso_oe = oe_q;
endmodule

// File: rtl/spi_sr_engine_chk.sv
module spi_sr_engine_chk
  import spi_sr_pkg::*;
#(
  parameter int BUSY_CYCLES = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       miso,
  input logic       miso_oe,
  input logic       busy,
  input logic       wel,
  input logic       vol_en,
  input logic [5:0] sr1_hi,
  input logic [7:0] sr2
);
  localparam int RW = $clog2(BUSY_CYCLES + 2);
  logic [RW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  AST_SET_ONLY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((($past(sr2) & ~sr2) & SR2_OTP_MASK) == 8'h00)); // R10
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel)); // R8
  AST_WEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel); // R8
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= RW'(BUSY_CYCLES)); // R8
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_act) |-> !miso_oe); // R12
  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso); // R12
  AST_ARMED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(sr1_hi)) |-> ($past(wel) || $past(vol_en))); // R6
  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !wel && !vol_en)); // R13
endmodule

bind spi_sr_engine spi_sr_engine_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .miso(spi_miso), .miso_oe(spi_miso_oe),
  .busy(busy), .wel(wel), .vol_en(vol_en), .sr1_hi(sr1_now[7:2]), .sr2(sr2_now)
);

// File: tb/spi_sr_engine_test.sv
`timescale 1ns/1ps
module spi_sr_engine_test;
  localparam int H    = 8;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  int   mode = 0;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  always #2.5 clk = ~clk;

  spi_sr_engine #(.SYNC_STAGES(2), .BUSY_CYCLES(BUSY), .NV1_INIT(8'h08), .NV2_INIT(8'h02)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_open(input int m);
    @(negedge clk);
    mode = m;
    sclk = (m == 3);
    half();
    cs_n = 1'b0;
    half();
  endtask

  task automatic cs_close();
    if (mode == 0) begin sclk = 1'b0; half(); end
    cs_n = 1'b1;
    half(); half();
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sclk = 1'b0; mosi = b[i]; half();
      sclk = 1'b1; half();
    end
  endtask

  task automatic get_byte(input string tag);
    logic [7:0] b;
    bit oe_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; half();
      if (!miso_oe) oe_ok = 1'b0;
      b[i] = miso;
      sclk = 1'b1; half();
    end
    check(oe_ok, {tag, " R12 oe while driving"}, 0, 1);
    got_q.push_back(b);
  endtask

  // driver: queue expected bytes, then run the read frame
  task automatic read_sr(input logic [7:0] op, input int m, input logic [7:0] e,
                         input int n, input string tag);
    for (int k = 0; k < n; k++) begin exp_q.push_back(e); tag_q.push_back(tag); end
    cs_open(m);
    put_bits(op, 8);
    check(!miso_oe, {tag, " R12 oe before data"}, miso_oe, 0);
    for (int k = 0; k < n; k++) get_byte(tag);
    cs_close();
    check(!miso_oe && !miso, {tag, " R12 idle after frame"}, miso_oe, 0);
  endtask

  task automatic send(input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input int m);
    cs_open(m);
    put_bits(b0, 8);
    if (n > 1) put_bits(b1, 8);
    if (n > 2) put_bits(b2, 8);
    cs_close();
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops expectations as read bytes arrive
  initial begin
    forever begin
      wait (got_q.size() != 0);
      begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(!miso_oe && !miso, "R12 R13 reset idle output", miso_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    read_sr(8'h05, 0, 8'h08, 2, "R1 R3 sr1 repeated mode0");
    read_sr(8'h35, 3, 8'h02, 1, "R2 R4 sr2 mode3");
    read_sr(8'h05, 3, 8'h08, 1, "R4 sr1 mode3");

    send(2, 8'h01, 8'hAA, 8'h00, 0);
    read_sr(8'h05, 0, 8'h08, 1, "R6 unarmed write ignored");

    send(1, 8'h06, 8'h00, 8'h00, 0);
    read_sr(8'h05, 0, 8'h0A, 1, "R5 wel set");
    send(3, 8'h01, 8'hFF, 8'hC6, 0);
    read_sr(8'h05, 0, 8'hFF, 1, "R8 busy poll");
    send(1, 8'h50, 8'h00, 8'h00, 0);
    repeat (BUSY + 200) @(negedge clk);
    read_sr(8'h05, 0, 8'hFC, 1, "R8 busy and wel cleared");
    read_sr(8'h35, 0, 8'h42, 1, "R7 read-only sr2 bits kept");
    send(2, 8'h01, 8'h00, 8'h00, 0);
    read_sr(8'h05, 0, 8'hFC, 1, "R8 arming during busy ignored");

    send(1, 8'h50, 8'h00, 8'h00, 0);
    send(2, 8'h01, 8'h00, 8'h00, 0);
    read_sr(8'h05, 0, 8'h00, 1, "R9 volatile write no busy");
    send(2, 8'h01, 8'h10, 8'h00, 0);
    read_sr(8'h05, 0, 8'h00, 1, "R9 volatile arming one-shot");
    pulse_reset();
    check(!miso_oe, "R13 oe after reset", miso_oe, 0);
    read_sr(8'h05, 0, 8'hFC, 1, "R13 R9 reload from nonvolatile");

    send(1, 8'h06, 8'h00, 8'h00, 0);
    cs_open(0); put_bits(8'h01, 8); put_bits(8'h20, 8); put_bits(8'hFF, 3); cs_close();
    read_sr(8'h05, 0, 8'hFE, 1, "R11 partial byte drops write");
    send(2, 8'h01, 8'h20, 8'h00, 0);
    repeat (BUSY + 200) @(negedge clk);
    read_sr(8'h05, 0, 8'h20, 1, "R5 one data byte sr1");
    read_sr(8'h35, 0, 8'h42, 1, "R5 sr2 untouched by one byte");

    send(1, 8'h50, 8'h00, 8'h00, 3);
    send(3, 8'h01, 8'h20, 8'h39, 3);
    read_sr(8'h35, 3, 8'h39, 1, "R10 R4 volatile set of lock bits");
    send(1, 8'h50, 8'h00, 8'h00, 3);
    send(3, 8'h01, 8'h20, 8'h00, 3);
    read_sr(8'h35, 3, 8'h39, 1, "R10 volatile clear refused");
    pulse_reset();
    read_sr(8'h35, 0, 8'h42, 1, "R9 volatile lock lost at reset");

    send(1, 8'h06, 8'h00, 8'h00, 0);
    send(3, 8'h01, 8'h20, 8'h08, 0);
    repeat (BUSY + 200) @(negedge clk);
    send(1, 8'h06, 8'h00, 8'h00, 0);
    send(3, 8'h01, 8'h20, 8'h00, 0);
    repeat (BUSY + 200) @(negedge clk);
    pulse_reset();
    read_sr(8'h35, 0, 8'h08, 1, "R10 nonvolatile lock kept");

    wait (got_q.size() == 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule